// File: doc/BRIEF.md
# Direct-Mapped Copy-Back Data Cache

This block is a 16 KB direct-mapped data cache for a processor's load/store path. It has 512 lines of 32 bytes, and each line carries a stored tag and its own valid and dirty flags. On the CPU side it takes long (32-bit), word (16-bit) and byte accesses, prefetches and per-line maintenance commands. On the memory side it moves whole lines in single bursts over a request/acknowledge handshake.

Any access that misses allocates the indexed line, whether it is a read, a write or a prefetch. If the line being replaced is valid and dirty, the cache first writes it to memory at its old address and only then fetches the new line. Writes go into the cache and mark the line dirty (copy-back).

Maintenance commands act on the line that holds the given address:
- invalidate drops the line;
- purge writes the line back if it is dirty and then drops it;
- writeback writes the line back and keeps it.

A global command drops every line. A tag port reads a line's tag and flags directly, and it can also install a new tag and flags, writing back a dirty line first. The CPU holds its request and all of its fields steady until the cache raises `cpuReady` for one cycle. Read data is valid in that same cycle.

Top module: `copyback_dcache`

## Requirements
- R1: After reset every line is invalid and clean, and every stored tag reads as zero; a tag read (op 6) of any line returns 0.
- R2: The address is cut to its low 29 bits, so bits 31:29 are ignored. The line index is bits 13:5 and the stored tag is bits 28:5. A long read (op 0, size 2) that misses issues one burst read (`memWe`=0) at the line address and returns the little-endian word at byte offset bits 4:2. A repeated read of the same line hits with no memory traffic.
- R3: A word read (size 1) returns the 16-bit halfword at offset bits 4:1, sign-extended. A byte read (size 0) returns the byte at offset bits 4:0, sign-extended.
- R4: A write (op 1) that hits merges only the addressed bytes into the line and sets the line's dirty flag.
- R5: When a read, write or prefetch misses and the indexed line is valid and dirty, the line is first burst-written (`memWe`=1) at its old tag address with its current data. Only then is the new line burst-read and installed valid and clean.
- R6: A write that misses first fills the line from memory, then merges the written bytes, leaving the line valid and dirty.
- R7: A prefetch (op 2) fills the line on a miss and touches nothing else. A later read of that line hits.
- R8: Invalidate (op 3) completes in the cycle it is presented and issues no memory request. On a hit it clears only the valid flag, so any dirty data is lost.
- R9: Purge (op 4) on a hit of a dirty line writes the line back and then leaves it invalid and clean. On a clean hit it only clears the valid flag.
- R10: Writeback (op 5) on a hit of a dirty line writes it back and leaves it valid and clean. On a clean or missing line it completes with no memory traffic.
- R11: A tag read completes at once. It returns stored tag bits 28:10 in bits 28:10, the dirty flag in bit 1, the valid flag in bit 0, and zero elsewhere.
- R12: A tag write (op 7) first writes back the indexed line if it is valid and dirty. It then sets the tag from data bits 28:10 and address bits 9:5, valid from data bit 0 and dirty from data bit 1. The line data is left unchanged.
- R13: Global invalidate (op 8) completes at once, clears the valid and dirty flags of every line and issues no memory request.
- R14: A memory request keeps its address and direction steady until `memAck` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | CPU request present; held until `cpuReady` |
| cpuOp | input | 4 | 0 read, 1 write, 2 prefetch, 3 invalidate, 4 purge, 5 writeback, 6 tag read, 7 tag write, 8 global invalidate |
| cpuSize | input | 2 | 0 byte, 1 word, 2 long |
| cpuAddr | input | 32 | Access address, naturally aligned |
| cpuWdata | input | 32 | Write data, in the low bits for narrow writes |
| cpuReady | output | 1 | Request completes this cycle |
| cpuRdata | output | 32 | Read or tag-read result, valid with `cpuReady` |
| memReq | output | 1 | Line burst request |
| memWe | output | 1 | 1 burst write, 0 burst read |
| memAddr | output | 29 | Line-aligned memory address |
| memWdata | output | 256 | Line data for burst writes |
| memAck | input | 1 | One-cycle burst completion |
| memRdata | input | 256 | Line data for burst reads, valid with `memAck` |

## Verification
Some properties are checked on every cycle:
- the memory handshake stays steady until acknowledged;
- a writeback caused by a miss is always followed directly by a burst read;
- invalidate, tag read and global invalidate finish in one cycle and never reach memory.

Everything that depends on line contents and flags can only be shown by the bench's scenarios. This covers the data values returned with sign extension, byte merging, which victim address and data go out, dirty data being lost on invalidate, and the tags and flags that a tag write installs.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [3:0] {
    OP_READ   = 4'd0,
    OP_WRITE  = 4'd1,
    OP_PREF   = 4'd2,
    OP_INVAL  = 4'd3,
    OP_PURGE  = 4'd4,
    OP_WBACK  = 4'd5,
    OP_TAGRD  = 4'd6,
    OP_TAGWR  = 4'd7,
    OP_INVALL = 4'd8
  } dcOp_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL
  } dcState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic fillWe;   // install refilled line, valid and clean
    logic cpuWe;    // merge CPU bytes, set dirty
    logic clrValid;
    logic clrDirty;
    logic tagWe;    // install tag and flags from write data
    logic invAll;
    logic wbSel;    // memory address from stored tag
    logic tagRd;    // return tag word instead of data
  } dcStrobe_t;
endpackage

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuValid,
  input  logic [3:0] cpuOp,
  input  logic      hit,
  input  logic      victimDirty,
  input  logic      memAck,
  output logic      cpuReady,
  output logic      memReq,
  output logic      memWe,
  output dcStrobe_t stb
);
  dcState_e state, nxt;
  dcOp_e op;

  assign op = dcOp_e'(cpuOp);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    stb      = '0;
    cpuReady = 1'b0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    nxt      = state;
    stb.tagRd = (op == OP_TAGRD);
    case (state)
      ST_IDLE: if (cpuValid) begin
        case (op)
          OP_READ, OP_WRITE, OP_PREF:
            if (hit) begin
              cpuReady  = 1'b1;
              stb.cpuWe = (op == OP_WRITE);
            end else begin
              nxt = victimDirty ? ST_WB : ST_FILL;
            end
          OP_INVAL: begin
            cpuReady     = 1'b1;
            stb.clrValid = hit;
          end
          OP_PURGE:
            if (hit && victimDirty) nxt = ST_WB;
            else begin
              cpuReady     = 1'b1;
              stb.clrValid = hit;
            end
          OP_WBACK:
            if (hit && victimDirty) nxt = ST_WB;
            else cpuReady = 1'b1;
          OP_TAGWR:
            if (victimDirty) nxt = ST_WB;
            else begin
              cpuReady  = 1'b1;
              stb.tagWe = 1'b1;
            end
          OP_INVALL: begin
            cpuReady   = 1'b1;
            stb.invAll = 1'b1;
          end
          default: cpuReady = 1'b1;
        endcase
      end
      ST_WB: begin
        memReq    = 1'b1;
        memWe     = 1'b1;
        stb.wbSel = 1'b1;
        if (memAck) begin
          nxt = ST_IDLE;
          case (op)
            OP_READ, OP_WRITE, OP_PREF: nxt = ST_FILL;
            OP_PURGE: begin
              cpuReady     = 1'b1;
              stb.clrValid = 1'b1;
              stb.clrDirty = 1'b1;
            end
            OP_WBACK: begin
              cpuReady     = 1'b1;
              stb.clrDirty = 1'b1;
            end
            OP_TAGWR: begin
              cpuReady  = 1'b1;
              stb.tagWe = 1'b1;
            end
            default: cpuReady = 1'b1;
          endcase
        end
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          stb.fillWe = 1'b1;
          nxt        = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/dcache_datapath.sv
module dcache_datapath
  import dcache_pkg::*;
#(
  parameter int ADDR_W      = 29,
  parameter int LINE_BYTES  = 32,
  parameter int LINES       = 512,
  parameter int TAG_RD_LSB  = 10,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int IDX_W      = $clog2(LINES),
  localparam int TAG_W      = ADDR_W - OFF_W,
  localparam int LINE_W     = LINE_BYTES * 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  dcStrobe_t         stb,
  input  logic [ADDR_W-1:0] pAddr,
  input  logic [1:0]        cpuSize,
  input  logic [31:0]       cpuWdata,
  input  logic [LINE_W-1:0] memRdata,
  output logic              hit,
  output logic              victimDirty,
  output logic [31:0]       cpuRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LINE_W-1:0] memWdata
);
  logic [LINE_W-1:0] dataArr [LINES];
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [LINES-1:0]  validV, dirtyV;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [OFF_W-1:0]  off;
  logic [LINE_W-1:0] lineData, shifted, wideData;
  logic [LINE_BYTES-1:0] byteMask;
  logic [3:0]        mask4;
  logic [31:0]       tagWord;

  assign idx = pAddr[OFF_W +: IDX_W];
  assign tag = pAddr[ADDR_W-1:OFF_W];
  assign off = pAddr[OFF_W-1:0];

  assign lineData    = dataArr[idx];
  assign hit         = validV[idx] && (tagArr[idx] == tag);
  assign victimDirty = validV[idx] && dirtyV[idx];

  assign memAddr  = stb.wbSel ? {tagArr[idx], {OFF_W{1'b0}}} : {tag, {OFF_W{1'b0}}};
  assign memWdata = lineData;

  // Read path: shift the addressed bytes down, then size and sign-extend
  assign shifted = lineData >> {off, 3'b000};

  always_comb begin
    tagWord = '0;
    tagWord[ADDR_W-1:TAG_RD_LSB] = tagArr[idx][TAG_W-1:TAG_RD_LSB-OFF_W];
    tagWord[1] = dirtyV[idx];
    tagWord[0] = validV[idx];
  end

  always_comb begin
    if (stb.tagRd)          cpuRdata = tagWord;
    else if (cpuSize == 2'd0) cpuRdata = {{24{shifted[7]}}, shifted[7:0]};
    else if (cpuSize == 2'd1) cpuRdata = {{16{shifted[15]}}, shifted[15:0]};
    else                    cpuRdata = shifted[31:0];
  end

  // Write path: byte mask and data aligned to the offset
  always_comb begin
    case (cpuSize)
      2'd0:    mask4 = 4'b0001;
      2'd1:    mask4 = 4'b0011;
      default: mask4 = 4'b1111;
    endcase
  end
  assign byteMask = {{(LINE_BYTES-4){1'b0}}, mask4} << off;
  assign wideData = {{(LINE_W-32){1'b0}}, cpuWdata} << {off, 3'b000};

  always_ff @(posedge clk) begin
    if (stb.fillWe) dataArr[idx] <= memRdata;
    else if (stb.cpuWe) begin
      for (int b = 0; b < LINE_BYTES; b++)
        if (byteMask[b]) dataArr[idx][b*8 +: 8] <= wideData[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validV <= '0;
      dirtyV <= '0;
      for (int i = 0; i < LINES; i++) tagArr[i] <= '0;
    end else if (stb.invAll) begin
      validV <= '0;
      dirtyV <= '0;
    end else begin
      if (stb.fillWe) begin
        tagArr[idx] <= tag;
        validV[idx] <= 1'b1;
        dirtyV[idx] <= 1'b0;
      end
      if (stb.cpuWe)    dirtyV[idx] <= 1'b1;
      if (stb.clrValid) validV[idx] <= 1'b0;
      if (stb.clrDirty) dirtyV[idx] <= 1'b0;
      if (stb.tagWe) begin
        tagArr[idx] <= {cpuWdata[ADDR_W-1:TAG_RD_LSB], pAddr[TAG_RD_LSB-1:OFF_W]};
        validV[idx] <= cpuWdata[0];
        dirtyV[idx] <= cpuWdata[1];
      end
    end
  end
endmodule

// File: rtl/copyback_dcache.sv
module copyback_dcache
  import dcache_pkg::*;
#(
  parameter int ADDR_W     = 29,
  parameter int LINE_BYTES = 32,
  parameter int LINES      = 512,
  parameter int TAG_RD_LSB = 10,
  localparam int LINE_W    = LINE_BYTES * 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic [3:0]        cpuOp,
  input  logic [1:0]        cpuSize,
  input  logic [31:0]       cpuAddr,
  input  logic [31:0]       cpuWdata,
  output logic              cpuReady,
  output logic [31:0]       cpuRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LINE_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [LINE_W-1:0] memRdata
);
  dcStrobe_t stb;
  logic hit, victimDirty;
  logic [ADDR_W-1:0] pAddr;

  assign pAddr = cpuAddr[ADDR_W-1:0];

  dcache_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuOp(cpuOp),
    .hit(hit), .victimDirty(victimDirty), .memAck(memAck),
    .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe), .stb(stb)
  );

  dcache_datapath #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LINES(LINES), .TAG_RD_LSB(TAG_RD_LSB)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .pAddr(pAddr), .cpuSize(cpuSize),
    .cpuWdata(cpuWdata), .memRdata(memRdata), .hit(hit), .victimDirty(victimDirty),
    .cpuRdata(cpuRdata), .memAddr(memAddr), .memWdata(memWdata)
  );
endmodule

// File: rtl/copyback_dcache_chk.sv
module copyback_dcache_chk #(
  parameter int ADDR_W = 29
)(
  input logic              clk,
  input logic              rstN,
  input logic              cpuValid,
  input logic [3:0]        cpuOp,
  input logic              cpuReady,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr
);
  logic accessOp;
  assign accessOp = (cpuOp == 4'd0) || (cpuOp == 4'd1) || (cpuOp == 4'd2);

  // R14
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  // R5
  victim_then_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid && accessOp && memReq && memWe && memAck |=> memReq && !memWe);

  // R8
  inval_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid && cpuOp == 4'd3 && !memReq |-> cpuReady);

  // R11
  tagrd_fast_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid && cpuOp == 4'd6 && !memReq |-> cpuReady);

  // R13
  invall_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid && cpuOp == 4'd8 && !memReq |-> cpuReady ##1 !memReq);
endmodule

bind copyback_dcache copyback_dcache_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuOp(cpuOp),
  .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe),
  .memAck(memAck), .memAddr(memAddr)
);

// File: tb/copyback_dcache_test.sv
module copyback_dcache_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuValid = 1'b0;
  logic [3:0] cpuOp = '0;
  logic [1:0] cpuSize = '0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic cpuReady;
  logic [31:0] cpuRdata;
  logic memReq, memWe;
  logic [28:0] memAddr;
  logic [255:0] memWdata;
  logic memAck = 1'b0;
  logic [255:0] memRdata = '0;

  always #10 clk = ~clk;   // 50 MHz

  copyback_dcache uut (.*);

  int nTests = 0, nFail = 0;
  int fills = 0, wbs = 0, stabErr = 0;
  logic [28:0] lastWbAddr;
  logic [255:0] lastWbData;
  logic [255:0] bmem [logic [23:0]];

  function automatic logic [255:0] lineOf(logic [23:0] la);
    logic [255:0] l;
    if (bmem.exists(la)) return bmem[la];
    for (int i = 0; i < 8; i++) l[i*32 +: 32] = {la, 8'(i)};
    return l;
  endfunction

  // Memory model: three-cycle latency, one-cycle acknowledge, updated at negedge
  logic busy = 1'b0;
  int cnt = 0;
  logic [28:0] reqAddr;
  logic reqWe;
  always @(negedge clk) begin
    if (memAck) memAck = 1'b0;
    else if (memReq) begin
      if (!busy) begin
        busy = 1'b1; cnt = 0; reqAddr = memAddr; reqWe = memWe;
      end else if (memAddr !== reqAddr || memWe !== reqWe) stabErr++;
      cnt++;
      if (cnt == 3) begin
        if (reqWe) begin
          bmem[reqAddr[28:5]] = memWdata;
          wbs++; lastWbAddr = reqAddr; lastWbData = memWdata;
        end else begin
          memRdata = lineOf(reqAddr[28:5]);
          fills++;
        end
        memAck = 1'b1;
        busy = 1'b0;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doOp(int op, int sz, logic [31:0] a, logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    cpuValid = 1'b1; cpuOp = 4'(op); cpuSize = 2'(sz); cpuAddr = a; cpuWdata = d;
    #1;
    while (!cpuReady) begin
      @(negedge clk); #1;
    end
    r = cpuRdata;
    @(posedge clk); #1;
    cpuValid = 1'b0;
  endtask

  logic [31:0] r;
  int f0, w0;

  task automatic tResetState();
    doOp(6, 2, 32'h1040, 0, r);
    check("R1 tag read after reset", r, 32'h0);
    check("R1 no memory traffic", fills + wbs, 0);
  endtask

  task automatic tReadMiss();
    doOp(0, 2, 32'h1040, 0, r);
    check("R2 long read miss data", r, 32'h8200);
    check("R2 one fill", fills, 1);
    doOp(0, 2, 32'hE000_1044, 0, r);
    check("R2 hit with upper bits set", r, 32'h8201);
    check("R2 no extra fill", fills, 1);
  endtask

  task automatic tSignExt();
    bmem[24'h300] = {192'h0, 32'h0000_7F12, 32'h80F1_FF80};
    doOp(1 - 1 + 1 - 1, 1, 32'h6000, 0, r);
    check("R3 word low", r, 32'hFFFF_FF80);
    doOp(0, 1, 32'h6002, 0, r);  check("R3 word high", r, 32'hFFFF_80F1);
    doOp(0, 0, 32'h6001, 0, r);  check("R3 byte 0xFF", r, 32'hFFFF_FFFF);
    doOp(0, 0, 32'h6002, 0, r);  check("R3 byte 0xF1", r, 32'hFFFF_FFF1);
    doOp(0, 0, 32'h6004, 0, r);  check("R3 positive byte", r, 32'h0000_0012);
    doOp(0, 1, 32'h6004, 0, r);  check("R3 positive word", r, 32'h0000_7F12);
  endtask

  task automatic tWriteHit();
    doOp(1, 0, 32'h1041, 32'h0000_00AB, r);
    doOp(0, 2, 32'h1040, 0, r);
    check("R4 byte merged", r, 32'h0000_AB00);
    doOp(6, 2, 32'h1040, 0, r);
    check("R4 R11 tag word dirty valid", r, 32'h0000_1003);
  endtask

  task automatic tDirtyVictim();
    f0 = fills; w0 = wbs;
    doOp(0, 2, 32'h5040, 0, r);
    check("R5 new line data", r, 32'h0002_8200);
    check("R5 one writeback", wbs - w0, 1);
    check("R5 victim address", {3'b0, lastWbAddr}, 32'h1040);
    check("R5 victim data", lastWbData[31:0], 32'h0000_AB00);
    check("R5 one fill", fills - f0, 1);
    doOp(0, 2, 32'h1040, 0, r);
    check("R5 written-back data returns", r, 32'h0000_AB00);
    check("R5 clean victim no writeback", wbs - w0, 1);
  endtask

  task automatic tWriteMiss();
    f0 = fills;
    doOp(1, 2, 32'h2080, 32'hDEAD_BEEF, r);
    check("R6 fill on write miss", fills - f0, 1);
    doOp(0, 2, 32'h2080, 0, r);  check("R6 written word", r, 32'hDEAD_BEEF);
    doOp(0, 2, 32'h2084, 0, r);  check("R6 rest of line filled", r, 32'h0001_0401);
    doOp(6, 2, 32'h2080, 0, r);  check("R6 valid dirty", r, 32'h0000_2003);
  endtask

  task automatic tPrefetch();
    f0 = fills;
    doOp(2, 2, 32'h3000, 0, r);
    check("R7 prefetch fills", fills - f0, 1);
    doOp(0, 2, 32'h3008, 0, r);
    check("R7 read after prefetch", r, 32'h0001_8002);
    check("R7 read hits", fills - f0, 1);
  endtask

  task automatic tInvalidate();
    doOp(1, 2, 32'h3000, 32'h1111_1111, r);
    w0 = wbs; f0 = fills;
    doOp(3, 2, 32'h3000, 0, r);
    check("R8 no writeback", wbs - w0, 0);
    doOp(6, 2, 32'h3000, 0, r);
    check("R8 valid cleared only", r, 32'h0000_3002);
    doOp(0, 2, 32'h3000, 0, r);
    check("R8 dirty data lost", r, 32'h0001_8000);
    check("R8 refetch", fills - f0, 1);
    check("R8 still no writeback", wbs - w0, 0);
  endtask

  task automatic tPurge();
    doOp(1, 2, 32'h3004, 32'h2222_2222, r);
    w0 = wbs;
    doOp(4, 2, 32'h3000, 0, r);
    check("R9 purge writes back", wbs - w0, 1);
    check("R9 purge address", {3'b0, lastWbAddr}, 32'h3000);
    check("R9 purge data", lastWbData[63:32], 32'h2222_2222);
    doOp(6, 2, 32'h3000, 0, r);
    check("R9 invalid and clean", r, 32'h0000_3000);
    doOp(0, 2, 32'h3004, 0, r);
    check("R9 memory holds purged data", r, 32'h2222_2222);
  endtask

  task automatic tWriteback();
    doOp(1, 2, 32'h3008, 32'h3333_3333, r);
    w0 = wbs; f0 = fills;
    doOp(5, 2, 32'h3000, 0, r);
    check("R10 writeback issued", wbs - w0, 1);
    check("R10 writeback data", lastWbData[95:64], 32'h3333_3333);
    doOp(6, 2, 32'h3000, 0, r);
    check("R10 valid clean", r, 32'h0000_3001);
    doOp(5, 2, 32'h3000, 0, r);
    check("R10 clean line no traffic", wbs - w0, 1);
    doOp(0, 2, 32'h3008, 0, r);
    check("R10 line still hits", r, 32'h3333_3333);
    check("R10 no fill", fills - f0, 0);
  endtask

  task automatic tTagWrite();
    doOp(1, 2, 32'h300C, 32'h4444_4444, r);
    w0 = wbs; f0 = fills;
    doOp(7, 2, 32'h300C, 32'h0000_B001, r);
    check("R12 dirty line written first", wbs - w0, 1);
    check("R12 old address", {3'b0, lastWbAddr}, 32'h3000);
    check("R12 old data", lastWbData[127:96], 32'h4444_4444);
    doOp(6, 2, 32'h300C, 0, r);
    check("R12 R11 installed tag and flags", r, 32'h0000_B001);
    doOp(0, 2, 32'h B00C, 0, r);
    check("R12 data kept, new tag hits", r, 32'h4444_4444);
    check("R12 no fill", fills - f0, 0);
  endtask

  task automatic tGlobalInval();
    doOp(1, 2, 32'h2080, 32'h5555_5555, r);
    w0 = wbs; f0 = fills;
    doOp(8, 2, 32'h0, 0, r);
    check("R13 no writeback", wbs - w0, 0);
    doOp(6, 2, 32'h2080, 0, r);
    check("R13 flags cleared", r, 32'h0000_2000);
    doOp(6, 2, 32'h5040, 0, r);
    check("R13 other line cleared", r, 32'h0000_1000);
    doOp(0, 2, 32'h2080, 0, r);
    check("R13 dirty data dropped", r, 32'h0001_0400);
    check("R13 refetch, no writeback", (fills - f0) * 16 + (wbs - w0), 32'h10);
  endtask

  task automatic finish();
    check("R14 request stable until acknowledge", stabErr, 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R1 ready low while idle", {31'b0, cpuReady}, 0);
    tResetState();
    tReadMiss();
    tSignExt();
    tWriteHit();
    tDirtyVictim();
    tWriteMiss();
    tPrefetch();
    tInvalidate();
    tPurge();
    tWriteback();
    tTagWrite();
    tGlobalInval();
    finish();
  end
endmodule